// File: doc/BRIEF.md
# Long-Delay One-Shot Timer Controller

This block turns a free-running oscillator clock into a long one-shot interval. A binary divider of `STAGES` flip-flops counts oscillator cycles while the output is high. The output drops by itself when the top stage would be reached, which happens after 2^(STAGES-1) cycles. Three control inputs arrive asynchronously and pass through a two-flop synchronizer. A rising edge is then detected on each synchronized level. A start edge raises the output and restarts the count. A toggle edge inverts the output. An abort level holds everything cleared.

The block also has a hidden production-test mode. It is entered by an illegal overlap: the abort input rises while a start or toggle input is already high. In this mode the lower and upper halves of the divider count in parallel until both are saturated. When the abort input is released, the interval ends after only 2^(STAGES/2-1)+1 further cycles, so a tester can check the divider chain in about a thousand cycles instead of half a million. A later abort edge, or the power-on reset, leaves the mode.

Top module: `longdelay_timer`

## Requirements
- R1: While `por` is high at a clock edge, `timer_out` and `expire_pulse` become 0 and test mode is cleared.
- R2: A rising edge on `set_in` raises `timer_out` on the third clock edge after the input changes, with the count restarted from zero. This also applies when `timer_out` is already high.
- R3: Once started, `timer_out` stays high for exactly 2^(STAGES-1) clock cycles and then falls. `expire_pulse` is high for exactly the one cycle in which `timer_out` has just fallen through expiry.
- R4: A rising edge on `trig_in` inverts `timer_out`. A low-to-high inversion starts a full interval. A high-to-low inversion clears the count and does not pulse `expire_pulse`.
- R5: While the synchronized `reset_in` is high and test mode is off, `timer_out` is held low. Rising edges on `set_in` and `trig_in` in that period have no lasting effect.
- R6: When `reset_in` and `set_in` rise in the same cycle, the abort wins and test mode is not entered. When `set_in` and `trig_in` rise together, the start wins and `timer_out` goes high.
- R7: A rising `reset_in` seen while `set_in` or `trig_in` has been high for at least one synchronized cycle enters test mode. It clears the divider and drives `timer_out` high.
- R8: In test mode, while `reset_in` and `set_in` are both high, the low and high halves of the divider (STAGES/2-1 bits each, excluding the middle and top stages) each increment every cycle and saturate at all ones. `timer_out` stays high.
- R9: In test mode, after `reset_in` drops, the whole divider counts as one chain. From the saturated preload, `timer_out` falls with an `expire_pulse` 2^(STAGES/2-1)+1 cycles after the first cycle that sees `reset_in` low.
- R10: A `reset_in` rising edge with `set_in` and `trig_in` low leaves test mode and drives `timer_out` low. The next start then runs a full 2^(STAGES-1)-cycle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock driving the divider |
| por | input | 1 | Synchronous active-high power-on reset |
| set_in | input | 1 | Start request, asynchronous, acted on at its rising edge |
| reset_in | input | 1 | Abort level, asynchronous, highest priority |
| trig_in | input | 1 | Toggle request, asynchronous, acted on at its rising edge |
| timer_out | output | 1 | Registered one-shot output |
| expire_pulse | output | 1 | One-cycle strobe when the interval runs out |

## Verification
Most errors in the divider stay hidden at the ports until the interval ends. An offset or a wrong carry then shows up as a `timer_out` fall and `expire_pulse` that is early or late by an exact number of cycles, up to 2^(STAGES-1) cycles after the start. A wrong test-mode flag shows much sooner. Within three cycles of an abort edge, `timer_out` is high where it should be low, or low where it should be high. A bad saturation in the test preload moves the short test interval by a predictable number of cycles.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_CTRL = 3;
  localparam int IDX_SET  = 0;
  localparam int IDX_ABT  = 1;
  localparam int IDX_TRG  = 2;

  typedef struct packed {
    logic clear;
    logic run;
    logic load;
  } div_cmd_t;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_prev
);
  logic [DEPTH-1:0][WIDTH-1:0] chain;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= '0;
    else     lvl_prev <= chain[DEPTH-1];
  end

  assign lvl = chain[DEPTH-1];
endmodule

// File: rtl/stage_divider.sv
module stage_divider
  import timer_pkg::*;
#(
  parameter int STAGES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  div_cmd_t          cmd,
  output logic              lower_full,
  output logic [STAGES-1:0] count_q
);
  localparam int HALF = STAGES / 2;
  localparam int SEG  = HALF - 1;
  localparam int TOP  = STAGES - 1;

  logic [SEG-1:0] lo_seg;
  logic [SEG-1:0] hi_seg;

  assign lo_seg     = count_q[SEG-1:0];
  assign hi_seg     = count_q[TOP-1:HALF];
  assign lower_full = &count_q[TOP-1:0];

  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      count_q <= '0;
    end else if (cmd.load) begin
      if (!(&lo_seg)) count_q[SEG-1:0]  <= lo_seg + 1'b1;
      if (!(&hi_seg)) count_q[TOP-1:HALF] <= hi_seg + 1'b1;
    end else if (cmd.run) begin
      count_q <= count_q + 1'b1;
    end
  end

  // the top stage is only ever reached as a carry, which ends the interval
  assert_top_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !count_q[TOP]);

  // with no command the stages keep their value (test hold phase)
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmd.clear && !cmd.run && !cmd.load) |=> $stable(count_q));
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import timer_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CTRL-1:0] lvl,
  input  logic [NUM_CTRL-1:0] lvl_prev,
  input  logic                lower_full,
  output div_cmd_t            cmd,
  output logic                out_q,
  output logic                tc_q
);
  logic test_q;
  logic out_n, tc_n, test_n;
  logic set_rise, trg_rise, abt_rise, entry;

  assign set_rise = lvl[IDX_SET] & ~lvl_prev[IDX_SET];
  assign trg_rise = lvl[IDX_TRG] & ~lvl_prev[IDX_TRG];
  assign abt_rise = lvl[IDX_ABT] & ~lvl_prev[IDX_ABT];
  assign entry    = abt_rise &
                    ((lvl[IDX_SET] & lvl_prev[IDX_SET]) |
                     (lvl[IDX_TRG] & lvl_prev[IDX_TRG]));

  always_comb begin
    out_n  = out_q;
    tc_n   = 1'b0;
    test_n = test_q;
    cmd    = '0;
    if (entry) begin
      test_n    = 1'b1;
      out_n     = 1'b1;
      cmd.clear = 1'b1;
    end else if (lvl[IDX_ABT]) begin
      if (abt_rise) test_n = 1'b0;
      if (test_q && !abt_rise) begin
        cmd.load = lvl[IDX_SET];
      end else begin
        out_n     = 1'b0;
        cmd.clear = 1'b1;
      end
    end else if (!test_q && set_rise) begin
      out_n     = 1'b1;
      cmd.clear = 1'b1;
    end else if (!test_q && trg_rise) begin
      out_n     = ~out_q;
      cmd.clear = 1'b1;
    end else if (out_q) begin
      if (lower_full) begin
        out_n     = 1'b0;
        tc_n      = 1'b1;
        cmd.clear = 1'b1;
      end else begin
        cmd.run = 1'b1;
      end
    end else begin
      cmd.clear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      tc_q   <= 1'b0;
      test_q <= 1'b0;
    end else begin
      out_q  <= out_n;
      tc_q   <= tc_n;
      test_q <= test_n;
    end
  end

  assert_tc_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (!out_q && $past(out_q)));

  assert_tc_single_R3: assert property (@(posedge clk) disable iff (rst)
    tc_q |=> !tc_q);

  assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
    (set_rise && !lvl[IDX_ABT] && !test_q) |=> out_q);

  assert_abort_low_R5: assert property (@(posedge clk) disable iff (rst)
    (lvl[IDX_ABT] && !abt_rise && !test_q) |=> !out_q);

  assert_test_entry_R7: assert property (@(posedge clk) disable iff (rst)
    entry |=> (test_q && out_q));
endmodule

// File: rtl/longdelay_timer.sv
module longdelay_timer
  import timer_pkg::*;
#(
  parameter int STAGES     = 20,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic por,
  input  logic set_in,
  input  logic reset_in,
  input  logic trig_in,
  output logic timer_out,
  output logic expire_pulse
);
  logic [NUM_CTRL-1:0] raw_in, lvl, lvl_prev;
  div_cmd_t            cmd;
  logic                lower_full;
  logic [STAGES-1:0]   count_q;

  always_comb begin
    raw_in          = '0;
    raw_in[IDX_SET] = set_in;
    raw_in[IDX_ABT] = reset_in;
    raw_in[IDX_TRG] = trig_in;
  end

  ctrl_sync #(.WIDTH(NUM_CTRL), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (por),
    .async_in (raw_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  oneshot_ctrl u_ctrl (
    .clk        (clk),
    .rst        (por),
    .lvl        (lvl),
    .lvl_prev   (lvl_prev),
    .lower_full (lower_full),
    .cmd        (cmd),
    .out_q      (timer_out),
    .tc_q       (expire_pulse)
  );

  stage_divider #(.STAGES(STAGES)) u_div (
    .clk        (clk),
    .rst        (por),
    .cmd        (cmd),
    .lower_full (lower_full),
    .count_q    (count_q)
  );
endmodule

// File: tb/test_longdelay_timer.sv
`timescale 1ns/1ps
module test_longdelay_timer;
  localparam int STAGES = 10;
  localparam int SYNC   = 2;

  function automatic int full_len(int s);
    return 1 << (s - 1);
  endfunction

  function automatic int test_len(int s);
    return (1 << (s / 2 - 1)) + 1;
  endfunction

  localparam int T  = full_len(STAGES);
  localparam int TT = test_len(STAGES);

  logic clk = 1'b0;
  logic por = 1'b1;
  logic set_in = 1'b0, reset_in = 1'b0, trig_in = 1'b0;
  logic timer_out, expire_pulse;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  longdelay_timer #(.STAGES(STAGES), .SYNC_DEPTH(SYNC)) i_longdelay_timer (
    .clk(clk), .por(por), .set_in(set_in), .reset_in(reset_in),
    .trig_in(trig_in), .timer_out(timer_out), .expire_pulse(expire_pulse)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic pulse_set();   set_in = 1;   tick(3); set_in = 0;   tick(5); endtask
  task automatic pulse_trg();   trig_in = 1;  tick(3); trig_in = 0;  tick(5); endtask
  task automatic pulse_abort(); reset_in = 1; tick(4); reset_in = 0; tick(4); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic model;
    logic tc_seen;
    void'($urandom(32'd20240611));
    tick(4);
    check(timer_out, 1'b0, "R1 out after por");
    check(expire_pulse, 1'b0, "R1 strobe after por");
    por = 0;
    tick(2);

    // R2 latency and R3 interval length
    set_in = 1;
    tick(SYNC);
    check(timer_out, 1'b0, "R2 before sync latency");
    tick(1);
    check(timer_out, 1'b1, "R2 out rises");
    set_in = 0;
    tick(T - 1);
    check(timer_out, 1'b1, "R3 last high cycle");
    tick(1);
    check(timer_out, 1'b0, "R3 out falls");
    check(expire_pulse, 1'b1, "R3 strobe with fall");
    tick(1);
    check(expire_pulse, 1'b0, "R3 strobe one cycle");

    // R2 restart while already high
    set_in = 1; tick(3); set_in = 0; tick(100);
    set_in = 1; tick(3); set_in = 0;
    tick(T - 1);
    check(timer_out, 1'b1, "R2 restart extends interval");
    tick(1);
    check(timer_out, 1'b0, "R2 restarted interval ends");

    // R4 toggle start and toggle stop
    trig_in = 1; tick(3);
    check(timer_out, 1'b1, "R4 toggle raises");
    trig_in = 0;
    tick(T - 1);
    check(timer_out, 1'b1, "R4 full interval from toggle");
    tick(1);
    check(expire_pulse, 1'b1, "R4 toggle interval expires");
    pulse_set();
    trig_in = 1;
    tc_seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      tc_seen |= expire_pulse;
    end
    trig_in = 0;
    check(timer_out, 1'b0, "R4 toggle lowers");
    check(tc_seen, 1'b0, "R4 no strobe on toggle stop");
    tick(4);

    // R5 abort holds low and masks edges
    pulse_set();
    reset_in = 1; tick(3);
    check(timer_out, 1'b0, "R5 abort forces low");
    set_in = 1; tick(3); set_in = 0;
    trig_in = 1; tick(3); trig_in = 0;
    tick(4);
    check(timer_out, 1'b0, "R5 edges ignored under abort");
    reset_in = 0; tick(6);
    check(timer_out, 1'b0, "R5 edges not remembered");

    // R6 coincident abort and start: abort wins, no test mode
    set_in = 1; reset_in = 1; tick(8);
    check(timer_out, 1'b0, "R6 abort beats start");
    set_in = 0; tick(3); reset_in = 0; tick(6);
    check(timer_out, 1'b0, "R6 no test mode entered");
    // R6 coincident start and toggle: start wins
    set_in = 1; trig_in = 1; tick(3); set_in = 0; trig_in = 0;
    check(timer_out, 1'b1, "R6 start beats toggle");
    pulse_abort();

    // constrained random mix of non-overlapping pulses
    for (int b = 0; b < 20; b++) begin
      pulse_abort();
      model = 1'b0;
      for (int k = 0; k < 8; k++) begin
        int op;
        op = int'($urandom_range(0, 4));
        case (op)
          0: begin pulse_set(); model = 1'b1; end
          1: begin pulse_trg(); model = ~model; end
          2: begin pulse_abort(); model = 1'b0; end
          3: begin set_in = 1; trig_in = 1; tick(3); set_in = 0; trig_in = 0; tick(5); model = 1'b1; end
          default: tick(8);
        endcase
        check(timer_out, model, op == 1 ? "R4 random toggle" :
                                op == 2 ? "R5 random abort" :
                                op == 3 ? "R6 random coincident" : "R2 random start");
      end
    end
    pulse_abort();

    // R7 entry, R8 preload, R9 short run
    set_in = 1; tick(6);
    reset_in = 1; tick(6);
    check(timer_out, 1'b1, "R7 test entry keeps out high");
    tick(30);
    check(timer_out, 1'b1, "R8 load phase out high");
    reset_in = 0;
    tick(2);
    set_in = 0;
    tick(SYNC + TT - 3);
    check(timer_out, 1'b1, "R9 last high cycle of test run");
    tick(1);
    check(timer_out, 1'b0, "R9 test run ends");
    check(expire_pulse, 1'b1, "R9 strobe on test expiry");

    // R10 exit and full interval afterwards
    reset_in = 1; tick(4);
    check(timer_out, 1'b0, "R10 exit abort lowers out");
    reset_in = 0; tick(4);
    set_in = 1; tick(3); set_in = 0;
    tick(T - 1);
    check(timer_out, 1'b1, "R10 full interval after exit");
    tick(1);
    check(timer_out, 1'b0, "R10 interval ends after exit");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule